// File: doc/BRIEF.md
# Periodic Framed Byte Stream Generator

This block is a free-running stimulus source that emits a framed stream of bytes with no input other than clock and reset. A phase counter cycles through five slots. Four of them carry a data beat and one is an idle gap. The final beat of each frame is flagged by an end-of-frame marker. Every beat carries the next value of an 8-bit running index, so a consumer sees 0, 1, 2, ... across beats and frames. The index wraps silently after 255.

The strobes are registered. Each one is decoded from the phase value one slot ahead, so it lines up with the phase it belongs to. Between beats the data bus is forced to zero and a separate drive-enable output is low. This drive-enable stands in for a tri-stated bus. The reset is asynchronous and active low. It clears the phase counter, the index and both strobes. Because the phase counter leaves reset at slot 0 with the strobe still low, the first frame after reset is one beat short (three beats).

Top module: `stream_gen`

## Requirements
- R1: While `rst_n` is low, `beat_vld`, `frame_end` and `bus_drive` are 0 and `beat_data` is 0.
- R2: The first clock edge after `rst_n` rises gives the first beat, with `beat_data` = 0. The first frame has exactly three beats (data 0, 1, 2), and `frame_end` is high on the third.
- R3: After reset release, clock edge number k (k = 1, 2, ...) gives slot k mod 5. `beat_vld` is high in slots 0 to 3 and low in slot 4, so it is 4 cycles on and 1 cycle off, with `bus_drive` equal to `beat_vld`.
- R4: `frame_end` is high exactly in slot 3. This is the fourth beat of a full frame, and it is always followed by the idle slot. `frame_end` is never high without `beat_vld`.
- R5: On every beat, `beat_data` equals the number of beats since reset release, modulo 256. Consecutive beats differ by exactly +1.
- R6: In the idle slot, `beat_data` is 0 and `bus_drive` is low. The index is not advanced, so the next beat continues from the last beat's value plus one.
- R7: The index wraps from 255 to 0 with no other effect on the stream.
- R8: Pulling `rst_n` low mid-stream clears all outputs at once, without a clock edge. The stream then restarts as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_vld | output | 1 | High in the four beat slots of each five-slot period |
| frame_end | output | 1 | High on the last beat of a frame |
| bus_drive | output | 1 | High when `beat_data` carries a meaningful byte |
| beat_data | output | 8 | Running index on beats, 0 otherwise |

## Verification
The bench goes after four corner cases.
- The shortened first frame after reset. A decoder that reads the current phase instead of the next one would shift every strobe by one slot.
- The idle slot. A design that advanced the index there would skip a value on the next beat.
- The 255-to-0 wrap, reached by a long run. A wrong-width index would never return to zero.
- Resets asserted asynchronously at random points in a frame. A synchronous reset or an uncleared counter would show stale beats or a misaligned restart.

// File: rtl/stream_gen_pkg.sv
`timescale 1ns/1ps
package stream_gen_pkg;

  // Next slot of a modulo-`period` phase sequence.
  function automatic int unsigned phase_advance(input int unsigned ph,
                                                input int unsigned period);
    return (ph >= period - 1) ? 0 : ph + 1;
  endfunction

  // A slot carries a beat when it lies before the idle tail.
  function automatic logic slot_is_beat(input int unsigned ph,
                                        input int unsigned on_beats);
    return ph < on_beats;
  endfunction

  // Slot carrying the end-of-frame marker.
  function automatic int unsigned closing_slot(input int unsigned on_beats);
    return on_beats - 1;
  endfunction

endpackage

// File: rtl/sg_phase_ctr.sv
`timescale 1ns/1ps
module sg_phase_ctr #(
  parameter int PERIOD = 5,
  localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase_q,
  output logic [PH_W-1:0] phase_nxt
);
  import stream_gen_pkg::*;

  assign phase_nxt = PH_W'(phase_advance(32'(phase_q), PERIOD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_nxt;
  end

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(phase_q) < PERIOD);

  // R3
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(phase_q) == PERIOD - 1) |=> (phase_q == '0));

endmodule

// File: rtl/sg_frame_dec.sv
`timescale 1ns/1ps
module sg_frame_dec #(
  parameter int PERIOD   = 5,
  parameter int ON_BEATS = 4,
  localparam int PH_W    = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] phase_nxt,
  output logic            vld_q,
  output logic            end_q
);
  import stream_gen_pkg::*;

  // Decode one slot ahead so the registered strobe lands in its own slot.
  logic vld_pre;
  logic end_pre;
  assign vld_pre = slot_is_beat(32'(phase_nxt), ON_BEATS);
  assign end_pre = (32'(phase_nxt) == closing_slot(ON_BEATS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      end_q <= 1'b0;
    end else begin
      vld_q <= vld_pre;
      end_q <= end_pre;
    end
  end

  // R4
  end_inside_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> vld_q);

  // R4
  end_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |=> !vld_q);

  // R3
  single_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |=> vld_q);

endmodule

// File: rtl/sg_index.sv
`timescale 1ns/1ps
module sg_index #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [DATA_W-1:0] idx_q
);

  function automatic logic [DATA_W-1:0] bump(input logic [DATA_W-1:0] v);
    return v + DATA_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (step) idx_q <= bump(idx_q);
  end

  // R6
  hold_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(idx_q));

  // R7
  index_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (idx_q == '1)) |=> (idx_q == '0));

endmodule

// File: rtl/stream_gen.sv
`timescale 1ns/1ps
module stream_gen #(
  parameter int PERIOD   = 5,
  parameter int ON_BEATS = 4,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              beat_vld,
  output logic              frame_end,
  output logic              bus_drive,
  output logic [DATA_W-1:0] beat_data
);
  localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PH_W-1:0]   phase_q;
  logic [PH_W-1:0]   phase_nxt;
  logic              vld_q;
  logic              end_q;
  logic [DATA_W-1:0] idx_q;

  sg_phase_ctr #(.PERIOD(PERIOD)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt)
  );

  sg_frame_dec #(.PERIOD(PERIOD), .ON_BEATS(ON_BEATS)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_nxt (phase_nxt),
    .vld_q     (vld_q),
    .end_q     (end_q)
  );

  sg_index #(.DATA_W(DATA_W)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (vld_q),
    .idx_q (idx_q)
  );

  assign beat_vld  = vld_q;
  assign frame_end = end_q;
  assign bus_drive = vld_q;
  assign beat_data = vld_q ? idx_q : '0;

  // R5
  beat_increment_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && $past(beat_vld)) |-> (beat_data == $past(beat_data) + DATA_W'(1)));

  // R6
  gap_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_drive) |=> (bus_drive && (beat_data == $past(idx_q))));

endmodule

// File: tb/test_stream_gen.sv
`timescale 1ns/1ps
module test_stream_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  wire        beat_vld;
  wire        frame_end;
  wire        bus_drive;
  wire [7:0]  beat_data;

  int checks = 0;
  int fails  = 0;
  int k      = 0;   // edges since reset release
  int beats  = 0;   // beats seen since reset release
  bit done   = 1'b0;

  stream_gen i_stream_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_vld  (beat_vld),
    .frame_end (frame_end),
    .bus_drive (bus_drive),
    .beat_data (beat_data)
  );

  always #10 clk = ~clk;   // 50 MHz

  function automatic bit exp_beat(input int edge_no);
    return (edge_no % 5) != 4;
  endfunction

  function automatic bit exp_end(input int edge_no);
    return (edge_no % 5) == 3;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", req, what, act, exp, k);
    end
  endtask

  task automatic check_quiet(input string req);
    check(req, "beat_vld",  32'(beat_vld),  32'd0);
    check(req, "frame_end", 32'(frame_end), 32'd0);
    check(req, "bus_drive", 32'(bus_drive), 32'd0);
    check(req, "beat_data", 32'(beat_data), 32'd0);
  endtask

  // One clock of the running stream, sampled 5 ns after the edge.
  task automatic run_cycle();
    bit    ev;
    string tv;
    string td;
    @(posedge clk);
    #5;
    k++;
    ev = exp_beat(k);
    tv = (k <= 4) ? "R2" : "R3";
    check(tv, "beat_vld",  32'(beat_vld),  32'(ev));
    check(tv, "bus_drive", 32'(bus_drive), 32'(ev));
    check((k <= 4) ? "R2" : "R4", "frame_end", 32'(frame_end), 32'(exp_end(k)));
    if (ev) begin
      if (beats >= 256)                td = "R7";
      else if (k > 5 && (k % 5) == 0) td = "R6";
      else if (k <= 4)                td = "R2";
      else                            td = "R5";
      check(td, "beat_data", 32'(beat_data), 32'(beats[7:0]));
      beats++;
    end else begin
      check("R6", "beat_data", 32'(beat_data), 32'd0);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) run_cycle();
  endtask

  // Asynchronous reset in the middle of a cycle, held for len edges.
  task automatic mid_reset(input int len);
    #3 rst_n = 1'b0;
    #1 check_quiet("R8");
    for (int i = 0; i < len; i++) begin
      @(posedge clk);
      #5 check_quiet("R1");
    end
    @(negedge clk);
    rst_n = 1'b1;
    k = 0;
    beats = 0;
  endtask

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20461);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #5 check_quiet("R1");
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R2: first shortened frame and a few full ones
    run(17);
    // R8 then R7: long run across the index wrap
    mid_reset(2);
    run(700);
    // random reset points and run lengths
    for (int t = 0; t < 30; t++) begin
      mid_reset(1 + int'($urandom % 3));
      run(1 + int'($urandom % 60));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule